// File: doc/BRIEF.md
# Host-Bus Memory Claim Decoder

This block sits in a host-to-PCI bridge and decides, for every memory transaction seen on the host bus, whether the bridge claims it and forwards it to PCI. It looks at the 36-bit address, the read/write direction and a flag that marks transactions wider than the supported address space. It then compares them against a set of configuration inputs: per-segment claim attributes for the legacy expansion area, a video-window enable, a high BIOS enable, a power-of-two memory gap, a start/end high gap and a top-of-memory threshold.

The result is registered. One clock after a request strobe the block presents a valid flag, a claim bit and a 4-bit reason code that names the rule which decided. A strap tells the instance whether it has the compatibility role or the auxiliary role, and that strap picks the reset value of the high BIOS enable. A second input makes the instance the subtractive default responder, which claims whatever no other agent positively decoded.

Top module: `hb_mem_claim`

## Requirements
- R1: `dec_valid` is high exactly in the cycle after a cycle with `req_valid` high. When it is low, `dec_claim` is 0 and `dec_reason` is 0 (none). When `dec_claim` is 1, `dec_reason` is one of the claim codes 2 to 8.
- R2: A request with `req_oversize` set is never claimed, even by the default responder, and its reason is 1.
- R3: Addresses A0000h–BFFFFh are claimed for both reads and writes with reason 2 only when `video_en` is 1.
- R4: Addresses C0000h–EFFFFh form 12 segments of 16 KB. Segment i uses `seg_attr[2i+1:2i]`: bit 2i grants reads and bit 2i+1 grants writes, so 00 disables, 01 is read-only, 10 is write-only and 11 is read/write. A granted access is claimed with reason 3.
- R5: Addresses F0000h–FFFFFh are one block. It is claimed for reads and writes with reason 4 while the internal high BIOS enable is set. That enable is loaded from `hbios_val` on a clock with `hbios_load` high, and a request in the same cycle still sees the old value.
- R6: Reset sets the high BIOS enable to 1 when `role_compat` is 1 and to 0 when it is 0.
- R7: An address below 1 MB that falls in one of the three legacy areas but is not granted by its attribute is never claimed by the gap, high-gap or top-of-memory rules. The default responder can still take it.
- R8: The gap covers MB numbers from `gap_base_mb` (nonzero) up to but excluding `gap_base_mb + 2^gap_size`. `gap_size` codes 0 to 5 give 1 to 32 MB, and codes 6 and 7 or a zero base turn the gap off. A hit is claimed with reason 5.
- R9: The high gap covers MB numbers from `hgap_start_mb` to `hgap_end_mb`, both included. A zero start, or an end below the start, turns it off. A hit is claimed with reason 6.
- R10: When `tom_en` is 1, every MB number at or above `tom_mb`, up to the 64 GB limit, is claimed with reason 7.
- R11: When several rules match, the priority is: legacy areas, then the gap, then the high gap, then top of memory.
- R12: A request that is not oversize and that no rule claims is claimed with reason 8 when `default_resp` is 1 and `other_claim` is 0. Otherwise it is unclaimed with reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_compat | input | 1 | Role strap: 1 compatibility, 0 auxiliary |
| default_resp | input | 1 | Instance acts as subtractive default responder |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 36 | Host memory address |
| req_write | input | 1 | 1 write, 0 read |
| req_oversize | input | 1 | Transaction address wider than 36 bits |
| other_claim | input | 1 | Another agent positively decoded this request |
| seg_attr | input | 24 | Two claim bits per 16 KB legacy segment |
| video_en | input | 1 | Claim enable for the video window |
| hbios_load | input | 1 | Load strobe for the high BIOS enable |
| hbios_val | input | 1 | Value loaded into the high BIOS enable |
| gap_base_mb | input | 16 | Gap base in MB units |
| gap_size | input | 3 | Gap size code |
| hgap_start_mb | input | 16 | High gap first MB |
| hgap_end_mb | input | 16 | High gap last MB |
| tom_mb | input | 16 | Top of main memory in MB units |
| tom_en | input | 1 | Top-of-memory claim enable |
| dec_valid | output | 1 | Decision valid |
| dec_claim | output | 1 | Bridge claims the request |
| dec_reason | output | 4 | Deciding rule code |

## Verification
The bench builds the block with its default parameters: a 36-bit address, 1 MB gap granularity and twelve 16 KB legacy segments. With these values, directed addresses can reach every legacy segment boundary, the last MB below 64 GB where a 32 MB gap is cut off by the address space, and both roles across separate resets. Random addresses are steered onto each configured edge and to one below and one above it, so the comparisons at the gap limit, the high gap end and the top-of-memory threshold are tested where they switch.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    localparam int HB_ADDR_W       = 36;
    localparam int HB_MB_SHIFT     = 20;
    localparam int HB_SEG_CNT      = 12;
    localparam int HB_SEG_SHIFT    = 14;
    localparam int HB_GAP_SZ_W     = 3;
    localparam int HB_GAP_MAX_CODE = 5;

    // Legacy area boundaries inside the first megabyte
    localparam int LG_VIDEO_LO = 'hA0000;
    localparam int LG_SEG_LO   = 'hC0000;
    localparam int LG_BIOS_LO  = 'hF0000;
    localparam int LG_TOP      = 'h100000;

    typedef enum logic [3:0] {
        RSN_NONE     = 4'd0,
        RSN_OVERSIZE = 4'd1,
        RSN_VIDEO    = 4'd2,
        RSN_SEGMENT  = 4'd3,
        RSN_HBIOS    = 4'd4,
        RSN_GAP      = 4'd5,
        RSN_HGAP     = 4'd6,
        RSN_TOM      = 4'd7,
        RSN_DEFAULT  = 4'd8
    } reason_t;

    typedef struct packed {
        logic    hit;
        logic    claim;
        reason_t reason;
    } dec_t;

    function automatic logic attr_grants(input logic [1:0] attr, input logic wr);
        return wr ? attr[1] : attr[0];
    endfunction

endpackage

// File: rtl/hbc_bios_enable.sv
module hbc_bios_enable (
    input  logic clk,
    input  logic rst,
    input  logic role_compat,
    input  logic load,
    input  logic val,
    output logic en
);
    always_ff @(posedge clk) begin
        if (rst)       en <= role_compat;
        else if (load) en <= val;
    end
endmodule

// File: rtl/hbc_legacy_dec.sv
module hbc_legacy_dec
    import hbc_pkg::*;
#(
    parameter int ADDR_W    = HB_ADDR_W,
    parameter int MB_SHIFT  = HB_MB_SHIFT,
    parameter int SEG_CNT   = HB_SEG_CNT,
    parameter int SEG_SHIFT = HB_SEG_SHIFT
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [2*SEG_CNT-1:0] seg_attr,
    input  logic                 video_en,
    input  logic                 hbios_en,
    output dec_t                 res
);
    localparam int LOW_W   = MB_SHIFT;
    localparam int CMP_W   = LOW_W + 1;
    localparam int SEG_LEN = 2 ** SEG_SHIFT;

    localparam logic [CMP_W-1:0] VID_LO = CMP_W'(LG_VIDEO_LO);
    localparam logic [CMP_W-1:0] SEG_LO = CMP_W'(LG_SEG_LO);
    localparam logic [CMP_W-1:0] BIO_LO = CMP_W'(LG_BIOS_LO);
    localparam logic [CMP_W-1:0] TOP    = CMP_W'(LG_TOP);

    logic             below_1m;
    logic [CMP_W-1:0] low;
    logic             in_video;
    logic             in_bios;
    logic [SEG_CNT-1:0] seg_hit;
    logic [SEG_CNT-1:0] seg_ok;

    assign below_1m = (addr[ADDR_W-1:MB_SHIFT] == '0);
    assign low      = {1'b0, addr[LOW_W-1:0]};
    assign in_video = below_1m && (low >= VID_LO) && (low < SEG_LO);
    assign in_bios  = below_1m && (low >= BIO_LO) && (low < TOP);

    for (genvar i = 0; i < SEG_CNT; i++) begin : g_seg
        localparam logic [CMP_W-1:0] S_LO = CMP_W'(LG_SEG_LO + i * SEG_LEN);
        localparam logic [CMP_W-1:0] S_HI = CMP_W'(LG_SEG_LO + (i + 1) * SEG_LEN);
        assign seg_hit[i] = below_1m && (low >= S_LO) && (low < S_HI);
        assign seg_ok[i]  = seg_hit[i] && attr_grants(seg_attr[2*i +: 2], wr);
    end

    always_comb begin
        res = '{hit: 1'b0, claim: 1'b0, reason: RSN_NONE};
        if (in_video) begin
            res.hit   = 1'b1;
            res.claim = video_en;
            if (video_en) res.reason = RSN_VIDEO;
        end else if (|seg_hit) begin
            res.hit   = 1'b1;
            res.claim = |seg_ok;
            if (|seg_ok) res.reason = RSN_SEGMENT;
        end else if (in_bios) begin
            res.hit   = 1'b1;
            res.claim = hbios_en;
            if (hbios_en) res.reason = RSN_HBIOS;
        end
    end
endmodule

// File: rtl/hbc_window_dec.sv
module hbc_window_dec
    import hbc_pkg::*;
#(
    parameter int MB_W         = HB_ADDR_W - HB_MB_SHIFT,
    parameter int GAP_SZ_W     = HB_GAP_SZ_W,
    parameter int GAP_MAX_CODE = HB_GAP_MAX_CODE
) (
    input  logic [MB_W-1:0]     mb,
    input  logic [MB_W-1:0]     gap_base,
    input  logic [GAP_SZ_W-1:0] gap_size,
    input  logic [MB_W-1:0]     hgap_start,
    input  logic [MB_W-1:0]     hgap_end,
    input  logic [MB_W-1:0]     tom,
    input  logic                tom_en,
    output dec_t                res
);
    localparam int EXT_W = MB_W + 1;

    logic [EXT_W-1:0] gap_lim;
    logic             gap_on;
    logic             gap_hit;
    logic             hgap_on;
    logic             hgap_hit;
    logic             tom_hit;

    // One bit wider than the MB number so a gap near 64 GB does not wrap
    assign gap_lim  = {1'b0, gap_base} + (EXT_W'(1) << gap_size);
    assign gap_on   = (gap_size <= GAP_SZ_W'(GAP_MAX_CODE)) && (gap_base != '0);
    assign gap_hit  = gap_on && (mb >= gap_base) && ({1'b0, mb} < gap_lim);

    assign hgap_on  = (hgap_start != '0) && (hgap_end >= hgap_start);
    assign hgap_hit = hgap_on && (mb >= hgap_start) && (mb <= hgap_end);

    assign tom_hit  = tom_en && (mb >= tom);

    always_comb begin
        res = '{hit: 1'b0, claim: 1'b0, reason: RSN_NONE};
        if (gap_hit) begin
            res = '{hit: 1'b1, claim: 1'b1, reason: RSN_GAP};
        end else if (hgap_hit) begin
            res = '{hit: 1'b1, claim: 1'b1, reason: RSN_HGAP};
        end else if (tom_hit) begin
            res = '{hit: 1'b1, claim: 1'b1, reason: RSN_TOM};
        end
    end
endmodule

// File: rtl/hb_mem_claim.sv
module hb_mem_claim
    import hbc_pkg::*;
#(
    parameter int ADDR_W       = HB_ADDR_W,
    parameter int MB_SHIFT     = HB_MB_SHIFT,
    parameter int SEG_CNT      = HB_SEG_CNT,
    parameter int SEG_SHIFT    = HB_SEG_SHIFT,
    parameter int GAP_SZ_W     = HB_GAP_SZ_W,
    parameter int GAP_MAX_CODE = HB_GAP_MAX_CODE,
    localparam int MB_W        = ADDR_W - MB_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 role_compat,
    input  logic                 default_resp,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 req_oversize,
    input  logic                 other_claim,
    input  logic [2*SEG_CNT-1:0] seg_attr,
    input  logic                 video_en,
    input  logic                 hbios_load,
    input  logic                 hbios_val,
    input  logic [MB_W-1:0]      gap_base_mb,
    input  logic [GAP_SZ_W-1:0]  gap_size,
    input  logic [MB_W-1:0]      hgap_start_mb,
    input  logic [MB_W-1:0]      hgap_end_mb,
    input  logic [MB_W-1:0]      tom_mb,
    input  logic                 tom_en,
    output logic                 dec_valid,
    output logic                 dec_claim,
    output logic [3:0]           dec_reason
);
    logic hbios_en;
    dec_t lg_res;
    dec_t win_res;
    dec_t nxt;

    hbc_bios_enable u_bios (
        .clk         (clk),
        .rst         (rst),
        .role_compat (role_compat),
        .load        (hbios_load),
        .val         (hbios_val),
        .en          (hbios_en)
    );

    hbc_legacy_dec #(
        .ADDR_W    (ADDR_W),
        .MB_SHIFT  (MB_SHIFT),
        .SEG_CNT   (SEG_CNT),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_legacy (
        .addr     (req_addr),
        .wr       (req_write),
        .seg_attr (seg_attr),
        .video_en (video_en),
        .hbios_en (hbios_en),
        .res      (lg_res)
    );

    hbc_window_dec #(
        .MB_W         (MB_W),
        .GAP_SZ_W     (GAP_SZ_W),
        .GAP_MAX_CODE (GAP_MAX_CODE)
    ) u_window (
        .mb         (req_addr[ADDR_W-1:MB_SHIFT]),
        .gap_base   (gap_base_mb),
        .gap_size   (gap_size),
        .hgap_start (hgap_start_mb),
        .hgap_end   (hgap_end_mb),
        .tom        (tom_mb),
        .tom_en     (tom_en),
        .res        (win_res)
    );

    // Priority: oversize, legacy areas (final when hit), windows, default
    always_comb begin
        nxt = '{hit: 1'b0, claim: 1'b0, reason: RSN_NONE};
        if (req_oversize) begin
            nxt.reason = RSN_OVERSIZE;
        end else if (lg_res.hit && lg_res.claim) begin
            nxt = lg_res;
        end else if (!lg_res.hit && win_res.hit) begin
            nxt = win_res;
        end else if (default_resp && !other_claim) begin
            nxt = '{hit: 1'b0, claim: 1'b1, reason: RSN_DEFAULT};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_claim  <= 1'b0;
            dec_reason <= RSN_NONE;
        end else begin
            dec_valid  <= req_valid;
            dec_claim  <= req_valid && nxt.claim;
            dec_reason <= req_valid ? nxt.reason : RSN_NONE;
        end
    end
endmodule

// File: rtl/hb_mem_claim_chk.sv
module hb_mem_claim_chk
    import hbc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_oversize,
    input logic       default_resp,
    input logic       other_claim,
    input logic       video_en,
    input logic       dec_valid,
    input logic       dec_claim,
    input logic [3:0] dec_reason
);
    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!dec_valid && !dec_claim && dec_reason == RSN_NONE)); // R1
    AST_CLAIM_CODE: assert property (@(posedge clk) disable iff (rst)
        dec_claim |-> (dec_reason >= RSN_VIDEO && dec_reason <= RSN_DEFAULT)); // R1
    AST_OVERSIZE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_oversize) |=> (!dec_claim && dec_reason == RSN_OVERSIZE)); // R2
    AST_VIDEO_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_reason == RSN_VIDEO) |-> $past(video_en)); // R3
    AST_DEFAULT_UNCLAIMED: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_reason == RSN_DEFAULT) |-> $past(default_resp && !other_claim)); // R12
endmodule

bind hb_mem_claim hb_mem_claim_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_oversize (req_oversize),
    .default_resp (default_resp),
    .other_claim  (other_claim),
    .video_en     (video_en),
    .dec_valid    (dec_valid),
    .dec_claim    (dec_claim),
    .dec_reason   (dec_reason)
);

// File: tb/hb_mem_claim_bench.sv
`timescale 1ns/1ps
module hb_mem_claim_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        role_compat = 1'b1;
    logic        default_resp = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_oversize = 1'b0;
    logic        other_claim = 1'b0;
    logic [23:0] seg_attr = '0;
    logic        video_en = 1'b0;
    logic        hbios_load = 1'b0;
    logic        hbios_val = 1'b0;
    logic [15:0] gap_base_mb = '0;
    logic [2:0]  gap_size = 3'd7;
    logic [15:0] hgap_start_mb = '0;
    logic [15:0] hgap_end_mb = '0;
    logic [15:0] tom_mb = '0;
    logic        tom_en = 1'b0;
    logic        dec_valid;
    logic        dec_claim;
    logic [3:0]  dec_reason;

    int n_tests = 0;
    int n_fail  = 0;
    logic model_hb = 1'b1;

    always #2.5 clk = ~clk;

    hb_mem_claim u_hb_mem_claim (
        .clk(clk), .rst(rst), .role_compat(role_compat), .default_resp(default_resp),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_oversize(req_oversize), .other_claim(other_claim), .seg_attr(seg_attr),
        .video_en(video_en), .hbios_load(hbios_load), .hbios_val(hbios_val),
        .gap_base_mb(gap_base_mb), .gap_size(gap_size), .hgap_start_mb(hgap_start_mb),
        .hgap_end_mb(hgap_end_mb), .tom_mb(tom_mb), .tom_en(tom_en),
        .dec_valid(dec_valid), .dec_claim(dec_claim), .dec_reason(dec_reason)
    );

    function automatic logic [35:0] mk(input logic [15:0] mb, input logic [19:0] lo);
        return {mb, lo};
    endfunction

    // Expected {claim, reason} from the requirements
    function automatic logic [4:0] ref_dec(input logic [35:0] a, input logic wr,
                                           input logic ovs, input logic oth);
        logic [15:0] mb = a[35:20];
        int lo = int'(a[19:0]);
        logic legacy_blocked = 1'b0;
        if (ovs) return {1'b0, 4'd1};
        if (mb == 16'd0 && lo >= 'hA0000 && lo < 'hC0000) begin
            if (video_en) return {1'b1, 4'd2};
            legacy_blocked = 1'b1;
        end else if (mb == 16'd0 && lo >= 'hC0000 && lo < 'hF0000) begin
            int idx = (lo - 'hC0000) / 'h4000;
            if (wr ? seg_attr[2*idx+1] : seg_attr[2*idx]) return {1'b1, 4'd3};
            legacy_blocked = 1'b1;
        end else if (mb == 16'd0 && lo >= 'hF0000) begin
            if (model_hb) return {1'b1, 4'd4};
            legacy_blocked = 1'b1;
        end
        if (!legacy_blocked) begin
            int d = int'(mb) - int'(gap_base_mb);
            if (gap_size <= 3'd5 && gap_base_mb != 16'd0 && d >= 0 && d < (1 << gap_size))
                return {1'b1, 4'd5};
            if (hgap_start_mb != 16'd0 && mb >= hgap_start_mb && mb <= hgap_end_mb)
                return {1'b1, 4'd6};
            if (tom_en && mb >= tom_mb) return {1'b1, 4'd7};
        end
        if (default_resp && !oth) return {1'b1, 4'd8};
        return {1'b0, 4'd0};
    endfunction

    task automatic check(input string tag, input logic v, input logic c, input logic [3:0] r,
                         input logic ev, input logic ec, input logic [3:0] er);
        n_tests++;
        if (v !== ev || c !== ec || r !== er) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b claim=%0b reason=%0d, expected valid=%0b claim=%0b reason=%0d",
                     tag, v, c, r, ev, ec, er);
        end
    endtask

    task automatic do_req(input string tag, input logic [35:0] a, input logic wr,
                          input logic ovs, input logic oth,
                          input logic ec, input logic [3:0] er);
        @(negedge clk);
        req_addr = a; req_write = wr; req_oversize = ovs; other_claim = oth;
        req_valid = 1'b1;
        @(negedge clk);
        check(tag, dec_valid, dec_claim, dec_reason, 1'b1, ec, er);
        req_valid = 1'b0;
    endtask

    task automatic do_model(input string tag, input logic [35:0] a, input logic wr,
                            input logic ovs, input logic oth);
        logic [4:0] e = ref_dec(a, wr, ovs, oth);
        do_req(tag, a, wr, ovs, oth, e[4], e[3:0]);
    endtask

    task automatic do_reset(input logic role);
        @(negedge clk);
        role_compat = role; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_hb = role;
    endtask

    task automatic load_hb(input logic v);
        @(negedge clk);
        hbios_load = 1'b1; hbios_val = v;
        @(negedge clk);
        hbios_load = 1'b0;
        model_hb = v;
    endtask

    function automatic logic [15:0] edge_mb(input logic [15:0] b);
        int k = int'($urandom % 3) - 1;
        return 16'(int'(b) + k);
    endfunction

    function automatic logic [19:0] legacy_lo();
        case ($urandom % 12)
            0: return 20'h9FFFF;  1: return 20'hA0000;  2: return 20'hBFFFF;
            3: return 20'hC0000;  4: return 20'hC3FFF;  5: return 20'hC4000;
            6: return 20'hDFFFF;  7: return 20'hE0000;  8: return 20'hEFFFF;
            9: return 20'hF0000;  10: return 20'hFFFFF;
            default: return 20'($urandom % 'h100000);
        endcase
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_0457));
        do_reset(1'b1);
        @(negedge clk);
        check("R1 reset idle", dec_valid, dec_claim, dec_reason, 1'b0, 1'b0, 4'd0);

        // R6: compatibility role enables high BIOS at reset
        do_req("R6 compat F0000 read", mk(16'h0, 20'hF0000), 1'b0, 1'b0, 1'b0, 1'b1, 4'd4);
        do_req("R5 FFFFF write", mk(16'h0, 20'hFFFFF), 1'b1, 1'b0, 1'b0, 1'b1, 4'd4);
        @(negedge clk);
        check("R1 idle after request", dec_valid, dec_claim, dec_reason, 1'b0, 1'b0, 4'd0);

        // R5: load enable off
        load_hb(1'b0);
        do_req("R5 disabled F8000", mk(16'h0, 20'hF8000), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        default_resp = 1'b1;
        do_req("R7 blocked legacy to default", mk(16'h0, 20'hF8000), 1'b0, 1'b0, 1'b0, 1'b1, 4'd8);
        default_resp = 1'b0;
        load_hb(1'b1);

        // R3 video window
        do_req("R3 video off", mk(16'h0, 20'hA0000), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        video_en = 1'b1;
        do_req("R3 video on write", mk(16'h0, 20'hBFFFF), 1'b1, 1'b0, 1'b0, 1'b1, 4'd2);
        do_req("R4 segment0 disabled", mk(16'h0, 20'hC0000), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        video_en = 1'b0;

        // R4 segments: seg0 read-only, seg11 write-only
        seg_attr = 24'h800001;
        do_req("R4 seg0 read", mk(16'h0, 20'hC3FFF), 1'b0, 1'b0, 1'b0, 1'b1, 4'd3);
        do_req("R4 seg0 write", mk(16'h0, 20'hC0000), 1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
        do_req("R4 seg1 read", mk(16'h0, 20'hC4000), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        do_req("R4 seg11 write", mk(16'h0, 20'hEFFFF), 1'b1, 1'b0, 1'b0, 1'b1, 4'd3);
        do_req("R4 seg11 read", mk(16'h0, 20'hEC000), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        seg_attr = '0;

        // R7: legacy area blocks top-of-memory
        tom_en = 1'b1; tom_mb = 16'h0;
        do_req("R7 video blocks tom", mk(16'h0, 20'hA0000), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        do_req("R10 below video tom", mk(16'h0, 20'h9FFFF), 1'b0, 1'b0, 1'b0, 1'b1, 4'd7);
        tom_en = 1'b0;

        // R8 gap
        gap_base_mb = 16'h10; gap_size = 3'd2;
        do_req("R8 gap below", mk(16'h0F, 20'hFFFFF), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        do_req("R8 gap first", mk(16'h10, 20'h0), 1'b0, 1'b0, 1'b0, 1'b1, 4'd5);
        do_req("R8 gap last", mk(16'h13, 20'hFFFFF), 1'b1, 1'b0, 1'b0, 1'b1, 4'd5);
        do_req("R8 gap above", mk(16'h14, 20'h0), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        gap_size = 3'd6;
        do_req("R8 code6 off", mk(16'h10, 20'h0), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        gap_base_mb = 16'hFFF0; gap_size = 3'd5;
        do_req("R8 gap at 64GB top", mk(16'hFFFF, 20'hFFFFF), 1'b0, 1'b0, 1'b0, 1'b1, 4'd5);
        do_req("R8 gap below base", mk(16'hFFEF, 20'hFFFFF), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        gap_base_mb = 16'h0; gap_size = 3'd0;
        do_req("R8 zero base off", mk(16'h0, 20'h00100), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        gap_size = 3'd7;

        // R9 high gap
        hgap_start_mb = 16'h100; hgap_end_mb = 16'h100;
        do_req("R9 hgap below", mk(16'hFF, 20'hFFFFF), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        do_req("R9 hgap hit", mk(16'h100, 20'hFFFFF), 1'b0, 1'b0, 1'b0, 1'b1, 4'd6);
        do_req("R9 hgap above", mk(16'h101, 20'h0), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        hgap_start_mb = 16'h200; hgap_end_mb = 16'h1FF;
        do_req("R9 end below start", mk(16'h200, 20'h0), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        hgap_start_mb = 16'h0; hgap_end_mb = 16'h0;

        // R10 top of memory
        tom_en = 1'b1; tom_mb = 16'h800;
        do_req("R10 tom below", mk(16'h7FF, 20'hFFFFF), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        do_req("R10 tom edge", mk(16'h800, 20'h0), 1'b1, 1'b0, 1'b0, 1'b1, 4'd7);
        do_req("R10 tom 64GB", mk(16'hFFFF, 20'hFFFFF), 1'b0, 1'b0, 1'b0, 1'b1, 4'd7);
        tom_en = 1'b0;
        do_req("R10 tom disabled", mk(16'hFFFF, 20'h0), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);

        // R11 priority among windows
        tom_en = 1'b1; gap_base_mb = 16'h800; gap_size = 3'd0;
        hgap_start_mb = 16'h800; hgap_end_mb = 16'h800;
        do_req("R11 gap first", mk(16'h800, 20'h5), 1'b0, 1'b0, 1'b0, 1'b1, 4'd5);
        gap_size = 3'd7;
        do_req("R11 hgap second", mk(16'h800, 20'h5), 1'b0, 1'b0, 1'b0, 1'b1, 4'd6);
        hgap_start_mb = 16'h0;
        do_req("R11 tom third", mk(16'h800, 20'h5), 1'b0, 1'b0, 1'b0, 1'b1, 4'd7);

        // R2 oversize beats everything
        default_resp = 1'b1;
        do_req("R2 oversize", mk(16'h800, 20'h5), 1'b0, 1'b1, 1'b0, 1'b0, 4'd1);
        tom_en = 1'b0; hgap_end_mb = 16'h0;

        // R12 default responder
        do_req("R12 other claimed", mk(16'h20, 20'h0), 1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
        do_req("R12 default claim", mk(16'h20, 20'h0), 1'b1, 1'b0, 1'b0, 1'b1, 4'd8);
        default_resp = 1'b0;
        do_req("R12 no default", mk(16'h20, 20'h0), 1'b1, 1'b0, 1'b0, 1'b0, 4'd0);

        // R6 auxiliary role
        do_reset(1'b0);
        do_req("R6 aux F0000 read", mk(16'h0, 20'hF0000), 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);

        // R11 random sweep against the reference function
        for (int it = 0; it < 4000; it++) begin
            logic [35:0] a;
            if (it % 250 == 0) begin
                video_en      = 1'($urandom);
                seg_attr      = 24'($urandom);
                gap_base_mb   = 16'($urandom);
                gap_size      = 3'($urandom);
                hgap_start_mb = 16'($urandom);
                hgap_end_mb   = 16'(int'(hgap_start_mb) + int'($urandom % 96) - 16);
                tom_mb        = 16'($urandom);
                tom_en        = 1'($urandom);
                default_resp  = 1'($urandom);
                if ($urandom % 2 == 0) load_hb(1'($urandom));
            end
            case ($urandom % 7)
                0: a = mk(16'h0, legacy_lo());
                1: a = mk(edge_mb(gap_base_mb), 20'($urandom));
                2: a = mk(edge_mb(16'(int'(gap_base_mb) + (1 << gap_size))), 20'($urandom));
                3: a = mk(edge_mb(hgap_start_mb), 20'($urandom));
                4: a = mk(edge_mb(hgap_end_mb), 20'($urandom));
                5: a = mk(edge_mb(tom_mb), 20'($urandom));
                default: a = 36'({$urandom, $urandom});
            endcase
            do_model("R11 random", a, 1'($urandom), ($urandom % 16 == 0), 1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule